// File: doc/BRIEF.md
# Power-On Strap Sampling Latch

This block serves two dual-purpose pads. Each pad reads a board strap level at power-up and then becomes a clock output. When reset is released, a window timer runs for a fixed number of reference-clock cycles. During that window both pad drivers are kept in high impedance, so an external pull resistor sets the level on each pad. That level reaches the block through a multi-flop synchroniser. In the last cycle of the window the synchronised levels are captured into a latch. In the same clock edge, a valid flag rises and the output enables are turned on. From then on the pads carry clock waveforms.

The captured values go to the rest of the chip. The level latched from the mode pad (pad 0) chooses the waveform driven on the other pad: 1 selects the 24 MHz source and 0 selects the 48 MHz source. The level latched from the select pad (pad 1) is a frequency-select bit. Pad 0 drives the reference clock once it is enabled. The latched values are frozen, and only a new reset (the stand-in for a power cycle) clears them. The window length is a parameter counted in reference cycles. The default is 28636 cycles, which is about 2 ms at 14.318 MHz.

Top module: `strap_sampler`

## Requirements
- R1: While reset is asserted, and directly after it, pad_oe is 00, pad_do is 00, straps_valid is 0, aux_sel_24 is 0 and freq_sel is 0.
- R2: For the first WINDOW_CYCLES-1 rising edges after reset release, pad_oe stays 00 and pad_do stays 00, whatever pad_di and the clock sources do.
- R3: straps_valid rises at rising edge number WINDOW_CYCLES after reset release and then stays high until reset is asserted again.
- R4: When pad_di is held steady through the window, aux_sel_24 equals the level of pad_di[0] and freq_sel equals the level of pad_di[1] once straps_valid is high.
- R5: The captured value of each pad is its pad_di level at rising edge WINDOW_CYCLES-2 after release. A change after that edge is not captured, and a change before it is.
- R6: Once straps_valid is high, aux_sel_24 and freq_sel do not change for any pad_di activity.
- R7: pad_oe becomes 11 in the same cycle that straps_valid rises, and it equals {straps_valid, straps_valid} at all times.
- R8: While enabled, pad_do[0] follows ref_src combinationally.
- R9: While enabled, pad_do[1] follows aux24_src when aux_sel_24 is 1 and aux48_src when it is 0.
- R10: Asserting reset at any point, including mid-window, clears the latch and the flag, and a full new window of WINDOW_CYCLES edges follows the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the window |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| pad_di | input | 2 | Levels read from the two pads |
| ref_src | input | 1 | Reference waveform for pad 0 |
| aux48_src | input | 1 | 48 MHz waveform for pad 1 |
| aux24_src | input | 1 | 24 MHz waveform for pad 1 |
| pad_oe | output | 2 | Pad driver enables, 1 = driving |
| pad_do | output | 2 | Pad output data, 0 while not enabled |
| straps_valid | output | 1 | High from capture until the next reset |
| aux_sel_24 | output | 1 | Latched pad 0 level, 1 = 24 MHz on pad 1 |
| freq_sel | output | 1 | Latched pad 1 level, frequency-select bit |

## Verification
Three events fall on the same edge at the end of the window: the latch capture and the driver turn-on, while a strap edge may still be travelling through the synchroniser. The bench moves a strap edge to just after, and then to just before, the last edge whose level still reaches the latch. It then requires the old value or the new value to be captured, matching the synchroniser latency counted in the requirements. In the same runs it requires the enables to be off one edge before capture and on at the capture edge.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int unsigned STRAP_PINS = 2;
  localparam int unsigned PIN_MODE   = 0;
  localparam int unsigned PIN_FSEL   = 1;

  typedef struct packed {
    logic freq_sel;
    logic aux_sel_24;
  } strap_cfg_t;

  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  function automatic logic pick_aux(input logic sel24, input logic c24, input logic c48);
    return sel24 ? c24 : c48;
  endfunction

  function automatic strap_cfg_t cfg_from_pads(input logic [STRAP_PINS-1:0] lv);
    strap_cfg_t c;
    c.aux_sel_24 = lv[PIN_MODE];
    c.freq_sel   = lv[PIN_FSEL];
    return c;
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst_n,
  output logic window_open,
  output logic capture_pulse
);
  import strap_pkg::*;
  localparam int unsigned CW = cnt_bits(WINDOW_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);
  localparam logic [CW-1:0] DONE = CW'(WINDOW_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q != DONE) cnt_q <= cnt_q + 1'b1;
  end

  assign window_open   = (cnt_q != DONE);
  assign capture_pulse = (cnt_q == LAST);
endmodule

// File: rtl/strap_capture.sv
module strap_capture (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  capture_pulse,
  input  logic [strap_pkg::STRAP_PINS-1:0]      levels,
  output strap_pkg::strap_cfg_t                 cfg,
  output logic                                  valid
);
  import strap_pkg::*;

  strap_cfg_t cfg_q;
  logic       valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else if (capture_pulse && !valid_q) begin
      cfg_q   <= cfg_from_pads(levels);
      valid_q <= 1'b1;
    end
  end

  assign cfg   = cfg_q;
  assign valid = valid_q;
endmodule

// File: rtl/strap_pad_drive.sv
module strap_pad_drive (
  input  logic                              enable,
  input  strap_pkg::strap_cfg_t             cfg,
  input  logic                              ref_src,
  input  logic                              aux48_src,
  input  logic                              aux24_src,
  output logic [strap_pkg::STRAP_PINS-1:0]  pad_oe,
  output logic [strap_pkg::STRAP_PINS-1:0]  pad_do
);
  import strap_pkg::*;

  logic [STRAP_PINS-1:0] wave;

  always_comb begin
    wave           = '0;
    wave[PIN_MODE] = ref_src;
    wave[PIN_FSEL] = pick_aux(cfg.aux_sel_24, aux24_src, aux48_src);
  end

  generate
    for (genvar p = 0; p < STRAP_PINS; p++) begin : g_pad
      assign pad_oe[p] = enable;
      assign pad_do[p] = enable & wave[p];
    end
  endgenerate
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler #(
  parameter int unsigned WINDOW_CYCLES = 28636,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pad_di,
  input  logic       ref_src,
  input  logic       aux48_src,
  input  logic       aux24_src,
  output logic [1:0] pad_oe,
  output logic [1:0] pad_do,
  output logic       straps_valid,
  output logic       aux_sel_24,
  output logic       freq_sel
);
  import strap_pkg::*;

  logic                  window_open;
  logic                  capture_pulse;
  logic [STRAP_PINS-1:0] sync_q;
  strap_cfg_t            cfg;
  logic                  valid;

  strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .window_open(window_open), .capture_pulse(capture_pulse)
  );

  strap_sync #(.WIDTH(STRAP_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_di), .dout(sync_q)
  );

  strap_capture u_cap (
    .clk(clk), .rst_n(rst_n), .capture_pulse(capture_pulse),
    .levels(sync_q), .cfg(cfg), .valid(valid)
  );

  strap_pad_drive u_drive (
    .enable(valid), .cfg(cfg), .ref_src(ref_src),
    .aux48_src(aux48_src), .aux24_src(aux24_src),
    .pad_oe(pad_oe), .pad_do(pad_do)
  );

  assign straps_valid = valid;
  assign aux_sel_24   = cfg.aux_sel_24;
  assign freq_sel     = cfg.freq_sel;
endmodule

// File: rtl/strap_sampler_chk.sv
module strap_sampler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       window_open,
  input logic       capture_pulse,
  input logic [1:0] sync_q,
  input logic [1:0] pad_oe,
  input logic [1:0] pad_do,
  input logic       straps_valid,
  input logic       aux_sel_24,
  input logic       freq_sel,
  input logic       ref_src,
  input logic       aux48_src,
  input logic       aux24_src
);
  // R2: no driving while the window is still open and nothing captured
  a_r2_no_drive_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    window_open && !straps_valid |-> pad_oe == 2'b00 && pad_do == 2'b00);

  // R3: flag rises only right after the capture cycle
  a_r3_rise_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(straps_valid) |-> $past(capture_pulse));

  a_r3_capture_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    capture_pulse |=> straps_valid);

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    straps_valid |=> straps_valid);

  // R4, R5: latch takes the synchroniser output present at the capture cycle
  a_r4_capture_takes_sync: assert property (@(posedge clk) disable iff (!rst_n)
    capture_pulse && !straps_valid |=>
      aux_sel_24 == $past(sync_q[0]) && freq_sel == $past(sync_q[1]));

  // R6: frozen after capture
  a_r6_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    straps_valid && $past(straps_valid) |-> $stable(aux_sel_24) && $stable(freq_sel));

  // R7, R8, R9: pad enables and data relative to the flag and sources
  always_comb begin
    if (rst_n) begin
      a_r7_oe_tracks_flag: assert (pad_oe == {straps_valid, straps_valid});
      if (straps_valid) begin
        a_r8_ref_on_pad0: assert (pad_do[0] == ref_src);
        a_r9_aux_on_pad1: assert (pad_do[1] == (aux_sel_24 ? aux24_src : aux48_src));
      end
    end
  end
endmodule

bind strap_sampler strap_sampler_chk i_chk (
  .clk(clk), .rst_n(rst_n), .window_open(window_open),
  .capture_pulse(capture_pulse), .sync_q(sync_q),
  .pad_oe(pad_oe), .pad_do(pad_do), .straps_valid(straps_valid),
  .aux_sel_24(aux_sel_24), .freq_sel(freq_sel), .ref_src(ref_src),
  .aux48_src(aux48_src), .aux24_src(aux24_src)
);

// File: tb/test_strap_sampler.sv
`timescale 1ns/1ps
module test_strap_sampler;
  localparam int unsigned W = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pad_di = 2'b00;
  logic       ref_src = 1'b0, aux48_src = 1'b0, aux24_src = 1'b0;
  logic [1:0] pad_oe, pad_do;
  logic       straps_valid, aux_sel_24, freq_sel;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  strap_sampler #(.WINDOW_CYCLES(W), .SYNC_STAGES(2)) i_strap_sampler (
    .clk(clk), .rst_n(rst_n), .pad_di(pad_di), .ref_src(ref_src),
    .aux48_src(aux48_src), .aux24_src(aux24_src), .pad_oe(pad_oe),
    .pad_do(pad_do), .straps_valid(straps_valid), .aux_sel_24(aux_sel_24),
    .freq_sel(freq_sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [1:0] strap);
    rst_n  = 1'b0;
    pad_di = strap;
    step();
    step();
    rst_n = 1'b1;
  endtask

  // run the window; pad_di becomes late_val just after edge change_edge (0 = never)
  task automatic run_window(input logic [1:0] late_val, input int change_edge);
    for (int k = 1; k <= W; k++) begin
      step();
      if (k < W) begin
        chk("R2 oe", {6'b0, pad_oe}, 8'h00);
        chk("R2 do", {6'b0, pad_do}, 8'h00);
        chk("R3 early", {7'b0, straps_valid}, 8'h00);
      end else begin
        chk("R3 rise", {7'b0, straps_valid}, 8'h01);
        chk("R7 oe on", {6'b0, pad_oe}, 8'h03);
      end
      if (k == change_edge) pad_di = late_val;
    end
  endtask

  task automatic check_outputs();
    for (int v = 0; v < 8; v++) begin
      ref_src = v[0]; aux48_src = v[1]; aux24_src = v[2];
      #0.2;
      chk("R8 pad0", {7'b0, pad_do[0]}, {7'b0, v[0]});
      chk("R9 pad1", {7'b0, pad_do[1]}, {7'b0, (aux_sel_24 ? v[2] : v[1])});
    end
  endtask

  initial begin
    #1;
    chk("R1 valid", {7'b0, straps_valid}, 8'h00);
    chk("R1 oe", {6'b0, pad_oe}, 8'h00);
    chk("R1 cfg", {6'b0, freq_sel, aux_sel_24}, 8'h00);

    for (int s = 0; s < 4; s++) begin
      logic [1:0] sv;
      sv = s[1:0];
      do_reset(sv);
      chk("R1 after reset", {5'b0, straps_valid, pad_oe}, 8'h00);
      run_window(sv, 0);
      chk("R4 aux_sel_24", {7'b0, aux_sel_24}, {7'b0, sv[0]});
      chk("R4 freq_sel", {7'b0, freq_sel}, {7'b0, sv[1]});
      check_outputs();
      for (int t = 0; t < 8; t++) begin
        pad_di = t[1:0] ^ 2'b11;
        step();
        chk("R6 frozen", {6'b0, freq_sel, aux_sel_24}, {6'b0, sv});
        chk("R3 sticky", {7'b0, straps_valid}, 8'h01);
        chk("R7 oe", {6'b0, pad_oe}, 8'h03);
      end
    end

    // R5: change just after edge W-2 is missed
    do_reset(2'b00);
    run_window(2'b11, W - 2);
    chk("R5 late change missed", {6'b0, freq_sel, aux_sel_24}, 8'h00);
    // R5: change just after edge W-3 is caught
    do_reset(2'b00);
    run_window(2'b11, W - 3);
    chk("R5 earlier change caught", {6'b0, freq_sel, aux_sel_24}, 8'h03);
    do_reset(2'b11);
    run_window(2'b01, W - 3);
    chk("R5 partial change caught", {6'b0, freq_sel, aux_sel_24}, 8'h01);

    // R10: reset mid-window, then a full new window
    do_reset(2'b10);
    for (int k = 0; k < 5; k++) step();
    rst_n = 1'b0;
    #0.5;
    chk("R10 cleared in reset", {5'b0, straps_valid, pad_oe}, 8'h00);
    step();
    rst_n = 1'b1;
    pad_di = 2'b01;
    run_window(2'b01, 0);
    chk("R10 new capture", {6'b0, freq_sel, aux_sel_24}, 8'h01);
    // R10: reset after capture clears latch
    rst_n = 1'b0;
    #0.5;
    chk("R10 latch cleared", {5'b0, straps_valid, freq_sel, aux_sel_24}, 8'h00);
    step();
    rst_n = 1'b1;
    run_window(2'b01, 0);
    chk("R10 recaptured", {6'b0, freq_sel, aux_sel_24}, 8'h01);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule